// File: doc/BRIEF.md
# GPIO and Logic-Cell Control Register Window

This block is a 256-location control and status window that a host processor reaches over a simple synchronous bus. The bus has a chip select, an 8-bit byte offset, a read strobe, write strobes and a 16-bit data path. Behind the window sit several kinds of state. Each GPIO port has an output level register, a direction register and a drive-select register. The block also holds two 8-bit banks of logic-cell flip-flops, a per-bank access mask, and a page register whose value is exported to the surrounding logic array. Reads of the window also return the live pin levels, the output-enable state of the pin drivers, and the protection and lock status.

The host always works in byte pairs. The word at even offset `a` holds byte `a` in bits 7:0 and byte `a+1` in bits 15:8. A parameter selects one of two ways to pick the lanes for a write. In the first, one write strobe is qualified by address bit 0 and an active-low high-byte enable. In the second, there are separate low and high write strobes. The logic array may also update the logic-cell flip-flops on any clock, one bit at a time. A host write to an unmasked bit takes priority over the array update.

Top module: `rf_gpio_window`

## Requirements
- R1: While `rst_n` is low, all writable registers (output levels, directions, drive selects, logic-cell banks, masks, page) clear to 0. `rdata` also clears to 0.
- R2: For port p (p < NUM_PORTS), the output level register is at offset 0x08+p, direction at 0x10+p and drive select at 0x18+p. Each reads back the value written. They drive `pin_out`, `pin_dir` and `pin_drv` on bits [8p+7:8p]. A direction bit of 1 marks the pin as an output and 0 as an input. When no write lane is enabled, these outputs hold.
- R3: Offset 0x00+p returns the levels on `pin_in` for port p as they are in the read cycle. Writes to it change nothing.
- R4: Offset 0x20+p returns `drv_en` for port p as it is in the read cycle. Writes to it change nothing.
- R5: Bank b (b = 0 or 1) of the logic cells is read and written at offset 0x30+b. Its mask register is at 0x32+b and reads back directly. On a host write, a bit whose mask is 1 keeps its value and a bit whose mask is 0 takes the written value. On a read, masked bits return 0. `mc_q` always shows the true contents, with bank b on bits [8b+7:8b].
- R6: On every clock, a flip-flop bit whose `mc_upd` bit is 1 loads the matching `mc_next` bit. On a host write to an unmasked bit in the same cycle, the host value wins. A host write never changes a masked bit, so that bit still takes the array update.
- R7: The page register is at offset 0xE0. It reads back the value written and drives `page_o`.
- R8: Offset 0xC0 returns `prot_main`. Offset 0xC2 returns `sec_lock` in bit 7 (1 = locked) and `prot_sec` in bits 3:0, with bits 6:4 at 0. Writes to either offset change nothing.
- R9: Every offset not listed here reads as 0, and writes to it change nothing. This includes port offsets for p >= NUM_PORTS, 0x34 to 0x3F, 0xC1, 0xC3 and 0xE1.
- R10: A read uses address bits 7:1 and returns {byte at a+1, byte at a}, where a is the even offset. `rdata` is registered: it shows the result in the cycle after `cs` and `rd` are both high, and it holds until the next read.
- R11: With LANE_SEL = 0, a write needs `cs` and `wr_lo`. The low lane is written when `addr[0]` is 0, and the high lane is written when `bhe_n` is 0. Without `cs`, nothing is written.
- R12: With LANE_SEL = 1, `cs` with `wr_lo` writes the low lane and `cs` with `wr_hi` writes the high lane, and `addr[0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Window select |
| addr | input | 8 | Byte offset within the window |
| rd | input | 1 | Read strobe |
| wr_lo | input | 1 | Write strobe (LANE_SEL=0) or low-lane write (LANE_SEL=1) |
| wr_hi | input | 1 | High-lane write (LANE_SEL=1 only) |
| bhe_n | input | 1 | Active-low high-byte enable (LANE_SEL=0 only) |
| wdata | input | 16 | Write data, low lane in bits 7:0 |
| rdata | output | 16 | Registered read data |
| pin_in | input | NUM_PORTS*8 | Live pin levels |
| drv_en | input | NUM_PORTS*8 | Pad driver enable state |
| pin_out | output | NUM_PORTS*8 | Output level registers |
| pin_dir | output | NUM_PORTS*8 | Direction registers, 1 = output |
| pin_drv | output | NUM_PORTS*8 | Drive-select registers |
| mc_next | input | 16 | Array next-state values for the logic cells |
| mc_upd | input | 16 | Per-bit array load enables |
| mc_q | output | 16 | Logic-cell flip-flop contents |
| prot_main | input | 8 | Main sector protection status |
| prot_sec | input | 4 | Secondary sector protection status |
| sec_lock | input | 1 | Security lock status |
| page_o | output | 8 | Page register value |

## Verification
The bench drives two instances, one for each lane-select scheme, from a single logical write stream, so single-lane writes and wrong lane encodings show up as a mismatch in one instance. It targets masked logic-cell writes made in the same cycle as array updates. A design that used the new mask, let the array override the host, or let the host clobber masked bits would leave `mc_q` wrong. It also reads masked bits, where leaking the stored value would show in `rdata`. Writes to read-only offsets, unimplemented offsets, ports beyond NUM_PORTS and the dead high byte of the page word would corrupt a neighbouring register or read back as non-zero if decoded too loosely. Writes without a chip select are also exercised, and they would change outputs if the lane gating were wrong.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Byte offsets of the register groups inside the window
  localparam logic [7:0] OFF_DIN  = 8'h00;
  localparam logic [7:0] OFF_DOUT = 8'h08;
  localparam logic [7:0] OFF_DIR  = 8'h10;
  localparam logic [7:0] OFF_DRV  = 8'h18;
  localparam logic [7:0] OFF_OE   = 8'h20;
  localparam logic [7:0] OFF_MC   = 8'h30;
  localparam logic [7:0] OFF_MASK = 8'h32;
  localparam logic [7:0] OFF_PROT = 8'hC0;
  localparam logic [7:0] OFF_SEC  = 8'hC2;
  localparam logic [7:0] OFF_PAGE = 8'hE0;

  localparam int MAX_PORTS = 8;
  localparam int MC_BANKS  = 2;

  // True when the enabled lanes of the current word cover byte offset off
  function automatic logic byte_we(input logic wen_lo, input logic wen_hi,
                                   input logic [7:0] word_addr, input logic [7:0] off);
    return (wen_lo && (word_addr == off)) ||
           (wen_hi && ({word_addr[7:1], 1'b1} == off));
  endfunction

  // Lane of the write word that carries byte offset off
  function automatic logic [7:0] lane_data(input logic [15:0] wdata, input logic [7:0] off);
    return off[0] ? wdata[15:8] : wdata[7:0];
  endfunction

  // Host load through a mask: set mask bits keep the old value
  function automatic logic [7:0] mask_load(input logic [7:0] old_v, input logic [7:0] new_v,
                                           input logic [7:0] mask);
    return (new_v & ~mask) | (old_v & mask);
  endfunction

  // Host view through a mask: set mask bits read as zero
  function automatic logic [7:0] mask_view(input logic [7:0] q, input logic [7:0] mask);
    return q & ~mask;
  endfunction

endpackage

// File: rtl/rf_lane_decode.sv
module rf_lane_decode #(
  parameter int LANE_SEL = 0
) (
  input  logic       cs,
  input  logic [7:0] addr,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic       bhe_n,
  output logic       wen_lo,
  output logic       wen_hi,
  output logic [7:0] word_addr
);

  assign word_addr = {addr[7:1], 1'b0};

  generate
    if (LANE_SEL == 0) begin : g_bhe
      // single strobe, lane picked by address bit 0 and high-byte enable
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign wen_lo = cs && wr_lo && !addr[0];
      assign wen_hi = cs && wr_lo && !bhe_n;
    end else begin : g_strobe
      // separate strobes per lane, address bit 0 not used
      logic unused_sel;
      assign unused_sel = bhe_n ^ addr[0];
      assign wen_lo = cs && wr_lo;
      assign wen_hi = cs && wr_hi;
    end
  endgenerate

endmodule

// File: rtl/rf_port_bank.sv
module rf_port_bank
  import rf_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wen_lo,
  input  logic                   wen_hi,
  input  logic [7:0]             word_addr,
  input  logic [15:0]            wdata,
  output logic [NUM_PORTS*8-1:0] dout_q,
  output logic [NUM_PORTS*8-1:0] dir_q,
  output logic [NUM_PORTS*8-1:0] drv_q
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [7:0] A_DOUT = OFF_DOUT + 8'(p);
    localparam logic [7:0] A_DIR  = OFF_DIR  + 8'(p);
    localparam logic [7:0] A_DRV  = OFF_DRV  + 8'(p);

    logic we_dout, we_dir, we_drv;
    assign we_dout = byte_we(wen_lo, wen_hi, word_addr, A_DOUT);
    assign we_dir  = byte_we(wen_lo, wen_hi, word_addr, A_DIR);
    assign we_drv  = byte_we(wen_lo, wen_hi, word_addr, A_DRV);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout_q[p*8 +: 8] <= '0;
        dir_q[p*8 +: 8]  <= '0;
        drv_q[p*8 +: 8]  <= '0;
      end else begin
        if (we_dout) dout_q[p*8 +: 8] <= lane_data(wdata, A_DOUT);
        if (we_dir)  dir_q[p*8 +: 8]  <= lane_data(wdata, A_DIR);
        if (we_drv)  drv_q[p*8 +: 8]  <= lane_data(wdata, A_DRV);
      end
    end
  end

endmodule

// File: rtl/rf_macro_bank.sv
module rf_macro_bank
  import rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen_lo,
  input  logic                 wen_hi,
  input  logic [7:0]           word_addr,
  input  logic [15:0]          wdata,
  input  logic [MC_BANKS*8-1:0] mc_next,
  input  logic [MC_BANKS*8-1:0] mc_upd,
  output logic [MC_BANKS*8-1:0] mc_q,
  output logic [MC_BANKS*8-1:0] mask_q
);

  for (genvar b = 0; b < MC_BANKS; b++) begin : g_bank
    localparam logic [7:0] A_MC   = OFF_MC   + 8'(b);
    localparam logic [7:0] A_MASK = OFF_MASK + 8'(b);

    logic [7:0] q, m, arr_nxt;
    logic       host_mc, host_mask;

    assign host_mc   = byte_we(wen_lo, wen_hi, word_addr, A_MC);
    assign host_mask = byte_we(wen_lo, wen_hi, word_addr, A_MASK);
    // array side: per-bit load from the logic array
    assign arr_nxt   = (mc_next[b*8 +: 8] & mc_upd[b*8 +: 8]) | (q & ~mc_upd[b*8 +: 8]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        m <= '0;
      end else begin
        // host wins on unmasked bits; masked bits keep the array result
        q <= host_mc ? mask_load(arr_nxt, lane_data(wdata, A_MC), m) : arr_nxt;
        if (host_mask) m <= lane_data(wdata, A_MASK);
      end
    end

    assign mc_q[b*8 +: 8]   = q;
    assign mask_q[b*8 +: 8] = m;
  end

endmodule

// File: rtl/rf_gpio_window.sv
module rf_gpio_window
  import rf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LANE_SEL  = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs,
  input  logic [7:0]             addr,
  input  logic                   rd,
  input  logic                   wr_lo,
  input  logic                   wr_hi,
  input  logic                   bhe_n,
  input  logic [15:0]            wdata,
  output logic [15:0]            rdata,
  input  logic [NUM_PORTS*8-1:0] pin_in,
  input  logic [NUM_PORTS*8-1:0] drv_en,
  output logic [NUM_PORTS*8-1:0] pin_out,
  output logic [NUM_PORTS*8-1:0] pin_dir,
  output logic [NUM_PORTS*8-1:0] pin_drv,
  input  logic [15:0]            mc_next,
  input  logic [15:0]            mc_upd,
  output logic [15:0]            mc_q,
  input  logic [7:0]             prot_main,
  input  logic [3:0]             prot_sec,
  input  logic                   sec_lock,
  output logic [7:0]             page_o
);

  localparam int PW = NUM_PORTS * 8;

  // named internal events, also used by the bound checker
  logic       wen_lo, wen_hi;
  logic [7:0] word_addr;
  logic       rd_fire;
  logic [7:0] rd_base;
  logic [7:0] page_q;
  logic [15:0] mask_q;
  logic [7:0] rd_byte [2];

  rf_lane_decode #(.LANE_SEL(LANE_SEL)) u_lane (
    .cs(cs), .addr(addr), .wr_lo(wr_lo), .wr_hi(wr_hi), .bhe_n(bhe_n),
    .wen_lo(wen_lo), .wen_hi(wen_hi), .word_addr(word_addr)
  );

  rf_port_bank #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk(clk), .rst_n(rst_n), .wen_lo(wen_lo), .wen_hi(wen_hi),
    .word_addr(word_addr), .wdata(wdata),
    .dout_q(pin_out), .dir_q(pin_dir), .drv_q(pin_drv)
  );

  rf_macro_bank u_macro (
    .clk(clk), .rst_n(rst_n), .wen_lo(wen_lo), .wen_hi(wen_hi),
    .word_addr(word_addr), .wdata(wdata),
    .mc_next(mc_next), .mc_upd(mc_upd), .mc_q(mc_q), .mask_q(mask_q)
  );

  // page register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else if (byte_we(wen_lo, wen_hi, word_addr, OFF_PAGE))
      page_q <= lane_data(wdata, OFF_PAGE);
  end
  assign page_o = page_q;

  // read side
  assign rd_fire = cs && rd;
  assign rd_base = {addr[7:1], 1'b0};

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      rd_byte[l] = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if ((rd_base | 8'(l)) == (OFF_DIN  + 8'(p))) rd_byte[l] = pin_in[p*8 +: 8];
        if ((rd_base | 8'(l)) == (OFF_DOUT + 8'(p))) rd_byte[l] = pin_out[p*8 +: 8];
        if ((rd_base | 8'(l)) == (OFF_DIR  + 8'(p))) rd_byte[l] = pin_dir[p*8 +: 8];
        if ((rd_base | 8'(l)) == (OFF_DRV  + 8'(p))) rd_byte[l] = pin_drv[p*8 +: 8];
        if ((rd_base | 8'(l)) == (OFF_OE   + 8'(p))) rd_byte[l] = drv_en[p*8 +: 8];
      end
      for (int b = 0; b < MC_BANKS; b++) begin
        if ((rd_base | 8'(l)) == (OFF_MC + 8'(b)))
          rd_byte[l] = mask_view(mc_q[b*8 +: 8], mask_q[b*8 +: 8]);
        if ((rd_base | 8'(l)) == (OFF_MASK + 8'(b)))
          rd_byte[l] = mask_q[b*8 +: 8];
      end
      if ((rd_base | 8'(l)) == OFF_PROT) rd_byte[l] = prot_main;
      if ((rd_base | 8'(l)) == OFF_SEC)  rd_byte[l] = {sec_lock, 3'b000, prot_sec};
      if ((rd_base | 8'(l)) == OFF_PAGE) rd_byte[l] = page_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_fire) rdata <= {rd_byte[1], rd_byte[0]};
  end

  logic unused_pw;
  assign unused_pw = (PW > MAX_PORTS * 8);

endmodule

// File: rtl/rf_gpio_window_chk.sv
module rf_gpio_window_chk
  import rf_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs,
  input logic                   rd,
  input logic [7:0]             addr,
  input logic [15:0]            wdata,
  input logic [15:0]            rdata,
  input logic [7:0]             page_o,
  input logic                   sec_lock,
  input logic [NUM_PORTS*8-1:0] pin_out,
  input logic [NUM_PORTS*8-1:0] pin_dir,
  input logic                   wen_lo,
  input logic                   wen_hi,
  input logic [7:0]             word_addr
);

  // R7: a low-lane write to the page word lands in page_o next cycle
  assert_page_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_lo && word_addr == OFF_PAGE) |=> (page_o == $past(wdata[7:0])));

  // R10: read data holds when no read is issued
  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> $stable(rdata));

  // R9: an unimplemented word reads as zero
  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && {addr[7:1], 1'b0} == 8'h80) |=> (rdata == 16'h0000));

  // R8: lock flag appears in bit 7 of the status word
  assert_lock_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && {addr[7:1], 1'b0} == OFF_SEC) |=> (rdata[7] == $past(sec_lock)));

  // R2: port outputs change only through an enabled write lane
  assert_port_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen_lo && !wen_hi) |=> ($stable(pin_out) && $stable(pin_dir)));

  // R11: no lane is enabled without the window select
  assert_lane_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_lo || wen_hi) |-> cs);

endmodule

bind rf_gpio_window rf_gpio_window_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .addr(addr), .wdata(wdata),
  .rdata(rdata), .page_o(page_o), .sec_lock(sec_lock), .pin_out(pin_out),
  .pin_dir(pin_dir), .wen_lo(wen_lo), .wen_hi(wen_hi), .word_addr(word_addr)
);

// File: tb/test_rf_gpio_window.sv
module test_rf_gpio_window;

  localparam int NP = 4;
  localparam int PW = NP * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // logical bus, encoded separately for each lane scheme
  logic        cs = 0, rd = 0;
  logic [7:0]  t_base = 0;
  logic        t_lo = 0, t_hi = 0;
  logic [15:0] wdata = 0;
  logic [PW-1:0] pin_in = 0, drv_en = 0;
  logic [15:0] mc_next = 0, mc_upd = 0;
  logic [7:0]  prot_main = 0;
  logic [3:0]  prot_sec = 0;
  logic        sec_lock = 0;

  logic [7:0] addr_a;
  logic       wr_a, bhe_n_a;
  assign addr_a  = {t_base[7:1], (!t_lo && t_hi)};
  assign wr_a    = t_lo || t_hi;
  assign bhe_n_a = !t_hi;

  logic [15:0] rdata_a, rdata_b, mcq_a, mcq_b;
  logic [PW-1:0] pout_a, pdir_a, pdrv_a, pout_b, pdir_b, pdrv_b;
  logic [7:0] page_a, page_b;

  rf_gpio_window #(.NUM_PORTS(NP), .LANE_SEL(0)) i_rf_gpio_window (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr_a), .rd(rd), .wr_lo(wr_a),
    .wr_hi(1'b0), .bhe_n(bhe_n_a), .wdata(wdata), .rdata(rdata_a),
    .pin_in(pin_in), .drv_en(drv_en), .pin_out(pout_a), .pin_dir(pdir_a),
    .pin_drv(pdrv_a), .mc_next(mc_next), .mc_upd(mc_upd), .mc_q(mcq_a),
    .prot_main(prot_main), .prot_sec(prot_sec), .sec_lock(sec_lock), .page_o(page_a)
  );

  rf_gpio_window #(.NUM_PORTS(NP), .LANE_SEL(1)) i_rf_gpio_window_s (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(t_base), .rd(rd), .wr_lo(t_lo),
    .wr_hi(t_hi), .bhe_n(1'b1), .wdata(wdata), .rdata(rdata_b),
    .pin_in(pin_in), .drv_en(drv_en), .pin_out(pout_b), .pin_dir(pdir_b),
    .pin_drv(pdrv_b), .mc_next(mc_next), .mc_upd(mc_upd), .mc_q(mcq_b),
    .prot_main(prot_main), .prot_sec(prot_sec), .sec_lock(sec_lock), .page_o(page_b)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_dout [NP];
  logic [7:0]  m_dir  [NP];
  logic [7:0]  m_drv  [NP];
  logic [7:0]  m_mc   [2];
  logic [7:0]  m_mask [2];
  logic [7:0]  m_page;
  logic [15:0] m_rdata;

  int checks = 0, errors = 0;
  string phase = "R1 reset state";

  function automatic logic [7:0] ref_byte(input int off);
    if (off < NP)                   return pin_in[off*8 +: 8];
    if (off >= 8  && off < 8 + NP)  return m_dout[off-8];
    if (off >= 16 && off < 16 + NP) return m_dir[off-16];
    if (off >= 24 && off < 24 + NP) return m_drv[off-24];
    if (off >= 32 && off < 32 + NP) return drv_en[(off-32)*8 +: 8];
    if (off == 'h30) return m_mc[0] & ~m_mask[0];
    if (off == 'h31) return m_mc[1] & ~m_mask[1];
    if (off == 'h32) return m_mask[0];
    if (off == 'h33) return m_mask[1];
    if (off == 'hC0) return prot_main;
    if (off == 'hC2) return {sec_lock, 3'b000, prot_sec};
    if (off == 'hE0) return m_page;
    return 8'h00;
  endfunction

  task automatic model_write(input int off, input logic [7:0] d);
    if (off >= 8  && off < 8 + NP)  m_dout[off-8]  = d;
    if (off >= 16 && off < 16 + NP) m_dir[off-16]  = d;
    if (off >= 24 && off < 24 + NP) m_drv[off-24]  = d;
    if (off == 'h32) m_mask[0] = d;
    if (off == 'h33) m_mask[1] = d;
    if (off == 'hE0) m_page = d;
  endtask

  logic [7:0] nmc [2];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin m_dout[i] = 0; m_dir[i] = 0; m_drv[i] = 0; end
      for (int b = 0; b < 2; b++) begin m_mc[b] = 0; m_mask[b] = 0; end
      m_page = 0;
      m_rdata = 0;
    end else begin
      int rb;
      rb = {24'd0, t_base[7:1], 1'b0};
      if (cs && rd) m_rdata = {ref_byte(rb + 1), ref_byte(rb)};
      for (int b = 0; b < 2; b++)
        nmc[b] = (mc_next[b*8 +: 8] & mc_upd[b*8 +: 8]) | (m_mc[b] & ~mc_upd[b*8 +: 8]);
      for (int l = 0; l < 2; l++) begin
        if (cs && ((l == 0) ? t_lo : t_hi)) begin
          logic [7:0] d;
          d = (l == 0) ? wdata[7:0] : wdata[15:8];
          if (rb + l == 'h30 || rb + l == 'h31)
            nmc[l] = (d & ~m_mask[l]) | (nmc[l] & m_mask[l]);
          else
            model_write(rb + l, d);
        end
      end
      for (int b = 0; b < 2; b++) m_mc[b] = nmc[b];
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s act %h exp %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [PW-1:0] e_out, e_dir, e_drv;
    for (int i = 0; i < NP; i++) begin
      e_out[i*8 +: 8] = m_dout[i];
      e_dir[i*8 +: 8] = m_dir[i];
      e_drv[i*8 +: 8] = m_drv[i];
    end
    chk("rdata bhe",  {16'd0, rdata_a}, {16'd0, m_rdata});
    chk("rdata strb", {16'd0, rdata_b}, {16'd0, m_rdata});
    chk("pin_out bhe",  pout_a, e_out);
    chk("pin_out strb", pout_b, e_out);
    chk("pin_dir bhe",  pdir_a, e_dir);
    chk("pin_dir strb", pdir_b, e_dir);
    chk("pin_drv bhe",  pdrv_a, e_drv);
    chk("pin_drv strb", pdrv_b, e_drv);
    chk("page bhe",  {24'd0, page_a}, {24'd0, m_page});
    chk("page strb", {24'd0, page_b}, {24'd0, m_page});
    chk("mc_q bhe",  {16'd0, mcq_a}, {16'd0, m_mc[1], m_mc[0]});
    chk("mc_q strb", {16'd0, mcq_b}, {16'd0, m_mc[1], m_mc[0]});
  end

  // ---------------- stimulus ----------------
  task automatic bus_wr(input logic [7:0] base, input logic [15:0] d,
                        input logic lo, input logic hi, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; rd = 0; t_base = base; wdata = d; t_lo = lo; t_hi = hi;
    @(negedge clk);
    cs = 0; t_lo = 0; t_hi = 0;
  endtask

  task automatic bus_rd(input logic [7:0] base);
    @(negedge clk);
    cs = 1; rd = 1; t_base = base; t_lo = 0; t_hi = 0;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, act hung exp done");
    summary();
    $finish;
  end

  logic [7:0] bases [21] = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h08, 8'h0A, 8'h0C, 8'h10,
                             8'h12, 8'h18, 8'h1A, 8'h20, 8'h22, 8'h30, 8'h32, 8'h34,
                             8'h80, 8'hC0, 8'hC2, 8'hE0, 8'hFE};

  initial begin
    // R1: reset clears every register and the read data
    repeat (3) @(negedge clk);
    rst_n = 1;
    foreach (bases[i]) bus_rd(bases[i]);

    phase = "R2 port registers";
    bus_wr(8'h08, 16'hA55A, 1, 1);
    bus_wr(8'h0A, 16'h1234, 1, 1);
    bus_wr(8'h10, 16'hF00F, 1, 1);
    bus_wr(8'h18, 16'h3CC3, 1, 1);
    bus_rd(8'h08); bus_rd(8'h0A); bus_rd(8'h10); bus_rd(8'h18);

    phase = "R11 R12 single lane writes";
    bus_wr(8'h0A, 16'hBEEF, 0, 1);
    bus_rd(8'h0A);
    bus_wr(8'h0A, 16'hCAFE, 1, 0);
    bus_rd(8'h0A);
    bus_wr(8'h12, 16'h7788, 0, 1);
    bus_rd(8'h12);

    phase = "R11 write without select";
    bus_wr(8'h08, 16'h0000, 1, 1, 1'b0);
    bus_rd(8'h08);

    phase = "R3 live pin read";
    pin_in = 32'h89AB_CDEF;
    bus_rd(8'h00); bus_rd(8'h02);
    pin_in = 32'h0F1E_2D3C;
    bus_wr(8'h00, 16'hFFFF, 1, 1);
    bus_rd(8'h00); bus_rd(8'h02);

    phase = "R4 driver enable status";
    drv_en = 32'h5A5A_A5A5;
    bus_rd(8'h20); bus_rd(8'h22);
    bus_wr(8'h20, 16'h0000, 1, 1);
    bus_rd(8'h20);

    phase = "R5 masked logic-cell access";
    bus_wr(8'h32, 16'hF00F, 1, 1);
    bus_wr(8'h30, 16'hFFFF, 1, 1);
    bus_rd(8'h30); bus_rd(8'h32);
    bus_wr(8'h32, 16'h0000, 1, 1);
    bus_rd(8'h30);

    phase = "R6 array update against host write";
    bus_wr(8'h32, 16'h00FF, 1, 1);
    @(negedge clk);
    mc_next = 16'h0F0F; mc_upd = 16'h3333;
    bus_wr(8'h30, 16'hAAAA, 1, 1);
    mc_upd = 0;
    bus_rd(8'h30);
    mc_next = 16'hFFFF; mc_upd = 16'hFFFF;
    @(negedge clk);
    mc_upd = 0;
    bus_rd(8'h30);

    phase = "R7 page register";
    bus_wr(8'hE0, 16'h003C, 1, 0);
    bus_rd(8'hE0);
    bus_wr(8'hE0, 16'h9900, 0, 1);
    bus_rd(8'hE0);

    phase = "R8 protection and lock status";
    prot_main = 8'hA1; prot_sec = 4'h9; sec_lock = 1;
    bus_rd(8'hC0); bus_rd(8'hC2);
    bus_wr(8'hC0, 16'h5555, 1, 1);
    bus_wr(8'hC2, 16'h0000, 1, 1);
    bus_rd(8'hC0); bus_rd(8'hC2);
    sec_lock = 0;
    bus_rd(8'hC2);

    phase = "R9 unimplemented offsets";
    bus_wr(8'h80, 16'hFFFF, 1, 1);
    bus_wr(8'h0C, 16'hFFFF, 1, 1);
    bus_wr(8'h34, 16'hFFFF, 1, 1);
    bus_wr(8'h04, 16'hFFFF, 1, 1);
    bus_rd(8'h80); bus_rd(8'h0C); bus_rd(8'h34); bus_rd(8'h04); bus_rd(8'hFE);

    phase = "R10 read hold and pairing";
    bus_rd(8'h09);
    repeat (4) @(negedge clk);

    phase = "R2 R5 R6 R10 mixed traffic";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      b = bases[$urandom % 21];
      pin_in  = $urandom;
      drv_en  = $urandom;
      mc_next = 16'($urandom);
      mc_upd  = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0000;
      case ($urandom % 3)
        0: bus_rd(b);
        1: bus_wr(b, 16'($urandom), 1'($urandom), 1'($urandom));
        default: @(negedge clk);
      endcase
    end
    mc_upd = 0;
    @(negedge clk);
    @(negedge clk);

    summary();
    $finish;
  end

endmodule